// File: doc/BRIEF.md
# Mixed-Decay Chopping Phase Sequencer

This block drives one H-bridge through a fixed-length chopping period. It runs on a reference clock, one tick per eighth of the period. Every period opens with a charge interval, which ends when the current-reached flag (`nf`) is seen. After charge the bridge recirculates in slow decay. When mixed decay is enabled, the bridge switches to fast decay at a programmable eighth of the period. A 3-bit code sets how many of the last eighths run in fast decay, and the top code gives fast decay for the whole post-charge time.

At the last tick of a period the block samples the end-of-fast monitor flag (`rnf`). If that flag shows overshoot, the next period skips charge and goes straight to slow and then fast decay. The block has four gate enables, one for each upper and lower switch on the two bridge legs. It leaves one reference tick with every gate low between any two different conducting pairs. An all-off request blanks the gates at once, and the sequence restarts only at the next period boundary.

Top module: `chop_sequencer`

## Requirements
- R1: A period is 8 reference ticks. Every period that is not cancelled starts in charge. With `polarity`=0 charge drives `hi_a`+`lo_b`; with `polarity`=1 it drives `hi_b`+`lo_a`.
- R2: Charge holds while `nf` is low at the clock edge. The first mid-period edge with `nf` high leaves charge. Slow decay drives `lo_a`+`lo_b`.
- R3: With `mix_en`=1 and code c in 0..6, fast decay occupies period slots 7-c..7. These are the last c+1 eighths, counting slot 0 as the first tick of the period. Fast decay drives the diagonal opposite the charge diagonal and stays until the period ends.
- R4: With `mix_en`=1 and code 7, fast decay covers all of the period after charge.
- R5: With `mix_en`=0 the period after charge stays in slow decay, whatever the code.
- R6: If the period ends in fast decay and `rnf` is high at the last edge, the next period skips charge. It begins in slow decay, or in fast decay when code 7 is set.
- R7: `rnf` has no effect when the period ends in any mode other than fast decay.
- R8: When the gates change from one nonzero pair to a different nonzero pair, all gates are low for exactly one tick first. No gap is added when starting from all-low. No leg ever has both of its switches on.
- R9: While `all_off` is high all four gate outputs are low at once, without waiting for a clock edge.
- R10: After `all_off` or reset, the gates stay low until the next period boundary, and that period starts in charge.
- R11: Reset (`rst_n` low, asynchronous) drives all gates low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one tick per eighth of a period |
| rst_n | input | 1 | Asynchronous active-low reset |
| all_off | input | 1 | Request to switch every gate off |
| polarity | input | 1 | Selects the charge diagonal |
| mix_en | input | 1 | Enables mixed/fast decay |
| mix_code | input | 3 | Fast-decay switch-point code |
| nf | input | 1 | Current reached set point |
| rnf | input | 1 | End-of-fast monitor: current above set point |
| hi_a | output | 1 | Upper switch, leg A |
| lo_a | output | 1 | Lower switch, leg A |
| hi_b | output | 1 | Upper switch, leg B |
| lo_b | output | 1 | Lower switch, leg B |

## Verification
Two things fall on the same edge at the last tick of a period: the charge-cancel decision taken from `rnf`, and the period-boundary restart of charge. The bench drives `rnf` high on that edge in several ways: after a fast-ending period under a mixed code, after one under code 7, and after a slow-only period. It judges whether the next tick shows slow, fast, or a break-before-make gap ahead of charge. A second coincidence comes from changing `polarity` while in charge so that the entry into fast decay selects the same gate pair. The bench expects no gap in that case.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic [1:0] {
        M_OFF    = 2'd0,
        M_CHARGE = 2'd1,
        M_SLOW   = 2'd2,
        M_FAST   = 2'd3
    } mode_e;

    typedef struct packed {
        logic hi_a;
        logic lo_a;
        logic hi_b;
        logic lo_b;
    } gate_t;

    // Switch pair requested by a bridge mode for a given polarity.
    function automatic gate_t pair_for(input mode_e m, input logic pol);
        gate_t g;
        g = '0;
        unique case (m)
            M_CHARGE: begin
                g.hi_a = ~pol;
                g.lo_b = ~pol;
                g.hi_b = pol;
                g.lo_a = pol;
            end
            M_FAST: begin
                g.hi_a = pol;
                g.lo_b = pol;
                g.hi_b = ~pol;
                g.lo_a = ~pol;
            end
            M_SLOW: begin
                g.lo_a = 1'b1;
                g.lo_b = 1'b1;
            end
            default: g = '0;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/chop_phase_ctr.sv
module chop_phase_ctr #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             all_off,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d,
    output logic             halt_q,
    output logic             halt_d,
    output logic             wrap_d
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             halt;
    } ctr_t;

    ctr_t s_d, s_q;

    always_comb begin
        s_d.cnt  = s_q.cnt + 1'b1;
        s_d.halt = all_off | (s_q.halt & (s_d.cnt != '0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt  <= '1;
            s_q.halt <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_q  = s_q.cnt;
    assign cnt_d  = s_d.cnt;
    assign halt_q = s_q.halt;
    assign halt_d = s_d.halt;
    assign wrap_d = (s_d.cnt == '0);

endmodule

// File: rtl/chop_mode_fsm.sv
module chop_mode_fsm
    import chop_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_d,
    input  logic             wrap_d,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] cnt_d,
    input  logic             mix_en,
    input  logic [CNT_W-1:0] mix_code,
    input  logic             nf,
    input  logic             rnf,
    output mode_e            mode_q,
    output mode_e            mode_d
);
    localparam logic [CNT_W-1:0] LAST = '1;

    typedef struct packed {
        mode_e mode;
    } fsm_t;

    fsm_t s_d, s_q;
    logic [CNT_W-1:0] fast_from;
    logic             in_fast;
    logic             cancel;

    always_comb begin
        fast_from = LAST - mix_code;
        in_fast   = mix_en && (cnt_d >= fast_from);
        cancel    = (s_q.mode == M_FAST) && (cnt_q == LAST) && rnf;
        s_d       = s_q;
        if (halt_d) begin
            s_d.mode = M_OFF;
        end else if (wrap_d) begin
            if (cancel) s_d.mode = in_fast ? M_FAST : M_SLOW;
            else        s_d.mode = M_CHARGE;
        end else begin
            unique case (s_q.mode)
                M_CHARGE: if (nf) s_d.mode = in_fast ? M_FAST : M_SLOW;
                M_SLOW:   if (in_fast) s_d.mode = M_FAST;
                default:  s_d.mode = s_q.mode;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.mode <= M_OFF;
        else        s_q      <= s_d;
    end

    assign mode_q = s_q.mode;
    assign mode_d = s_d.mode;

    AST_CHARGE_ONLY_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == M_CHARGE && cnt_q != '0) |-> $past(s_q.mode) == M_CHARGE); // R2

endmodule

// File: rtl/chop_gate_bbm.sv
module chop_gate_bbm
    import chop_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  halt_d,
    input  gate_t want,
    output gate_t gates_q
);
    typedef struct packed {
        gate_t g;
    } bbm_t;

    bbm_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (halt_d)                                 s_d.g = '0;
        else if (s_q.g != '0 && want != s_q.g)      s_d.g = '0;
        else                                        s_d.g = want;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.g <= '0;
        else        s_q   <= s_d;
    end

    assign gates_q = s_q.g;

    AST_GAP_BEFORE_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(s_q.g) != '0 && s_q.g != '0) |-> s_q.g == $past(s_q.g)); // R8
    AST_NO_LEG_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.g.hi_a && s_q.g.lo_a) && !(s_q.g.hi_b && s_q.g.lo_b)); // R8

endmodule

// File: rtl/chop_sequencer.sv
module chop_sequencer
    import chop_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             all_off,
    input  logic             polarity,
    input  logic             mix_en,
    input  logic [CNT_W-1:0] mix_code,
    input  logic             nf,
    input  logic             rnf,
    output logic             hi_a,
    output logic             lo_a,
    output logic             hi_b,
    output logic             lo_b
);
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             halt_q, halt_d, wrap_d;
    mode_e            mode_q, mode_d;
    gate_t            want, gates_q;

    chop_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .all_off(all_off),
        .cnt_q(cnt_q), .cnt_d(cnt_d),
        .halt_q(halt_q), .halt_d(halt_d), .wrap_d(wrap_d)
    );

    chop_mode_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .halt_d(halt_d), .wrap_d(wrap_d),
        .cnt_q(cnt_q), .cnt_d(cnt_d), .mix_en(mix_en), .mix_code(mix_code),
        .nf(nf), .rnf(rnf), .mode_q(mode_q), .mode_d(mode_d)
    );

    assign want = pair_for(mode_d, polarity);

    chop_gate_bbm u_bbm (
        .clk(clk), .rst_n(rst_n), .halt_d(halt_d),
        .want(want), .gates_q(gates_q)
    );

    assign hi_a = gates_q.hi_a & ~all_off;
    assign lo_a = gates_q.lo_a & ~all_off;
    assign hi_b = gates_q.hi_b & ~all_off;
    assign lo_b = gates_q.lo_b & ~all_off;

    AST_OFF_CLEARS_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(all_off) |-> gates_q == '0); // R9
    AST_HOLD_UNTIL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(halt_q) && cnt_q != '0) |-> (gates_q == '0 && mode_q == M_OFF)); // R10

endmodule

// File: tb/chop_sequencer_bench.sv
module chop_sequencer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       all_off = 1'b0;
    logic       polarity = 1'b0;
    logic       mix_en = 1'b0;
    logic [2:0] mix_code = 3'd0;
    logic       nf = 1'b0;
    logic       rnf = 1'b0;
    logic       hi_a, lo_a, hi_b, lo_b;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    chop_sequencer u_chop_sequencer (
        .clk(clk), .rst_n(rst_n), .all_off(all_off), .polarity(polarity),
        .mix_en(mix_en), .mix_code(mix_code), .nf(nf), .rnf(rnf),
        .hi_a(hi_a), .lo_a(lo_a), .hi_b(hi_b), .lo_b(lo_b)
    );

    // Gate word seen by the bench: {hi_a, lo_a, hi_b, lo_b}
    function automatic logic [15:0] v(input int r, input bit off, input bit pol,
                                       input bit en, input int code, input bit n,
                                       input bit m, input logic [3:0] x);
        return {4'(r), off, pol, en, 3'(code), n, m, x};
    endfunction

    localparam logic [15:0] VEC [64] = '{
        // polarity 0, mixed enabled, code 3 (fast in slots 4..7)
        v(1,0,0,1,3,0,0,4'b1001),   // R1 charge opens the period
        v(2,0,0,1,3,0,0,4'b1001),   // R2 nf low holds charge
        v(8,0,0,1,3,1,0,4'b0000),   // R8 charge->slow gap
        v(2,0,0,1,3,0,0,4'b0101),   // R2 slow decay
        v(8,0,0,1,3,0,0,4'b0000),   // R8 slow->fast gap at slot 4
        v(3,0,0,1,3,0,0,4'b0110),   // R3
        v(3,0,0,1,3,0,0,4'b0110),   // R3
        v(3,0,0,1,3,0,0,4'b0110),   // R3
        v(8,0,0,1,3,0,0,4'b0000),   // R8 fast->charge gap
        v(1,0,0,1,3,0,0,4'b1001),   // R1
        v(2,0,0,1,3,0,0,4'b1001),   // R2
        v(2,0,0,1,3,1,0,4'b0000),   // R2 nf at slot 3
        v(8,0,0,1,3,0,0,4'b0110),   // R8 no gap from all-low
        v(3,0,0,1,3,0,0,4'b0110),   // R3
        v(3,0,0,1,3,0,0,4'b0110),   // R3
        v(3,0,0,1,3,0,0,4'b0110),   // R3
        v(6,0,0,1,3,0,1,4'b0000),   // R6 cancel: slow, gap first
        v(6,0,0,1,3,0,0,4'b0101),   // R6
        v(6,0,0,1,3,0,0,4'b0101),   // R6
        v(6,0,0,1,3,0,0,4'b0101),   // R6
        v(3,0,0,1,3,0,0,4'b0000),   // R3
        v(3,0,0,1,3,0,0,4'b0110),   // R3
        v(3,0,0,1,3,0,0,4'b0110),   // R3
        v(3,0,0,1,3,0,0,4'b0110),   // R3
        v(1,0,0,1,3,0,0,4'b0000),   // R1
        v(1,0,0,1,3,0,0,4'b1001),   // R1
        // mixed disabled, code left at 3
        v(5,0,0,0,3,1,0,4'b0000),   // R5
        v(5,0,0,0,3,0,0,4'b0101),   // R5
        v(5,0,0,0,3,0,0,4'b0101),   // R5 slot 4 stays slow
        v(5,0,0,0,3,0,0,4'b0101),   // R5
        v(5,0,0,0,3,0,0,4'b0101),   // R5
        v(5,0,0,0,3,0,0,4'b0101),   // R5
        v(7,0,0,0,3,0,1,4'b0000),   // R7 rnf ignored after slow
        v(1,0,0,0,3,0,0,4'b1001),   // R1
        // polarity 1, code 7 (pure fast)
        v(4,0,1,1,7,1,0,4'b1001),   // R4 same pair, no gap
        v(4,0,1,1,7,0,0,4'b1001),   // R4
        v(4,0,1,1,7,0,0,4'b1001),   // R4
        v(4,0,1,1,7,0,0,4'b1001),   // R4
        v(4,0,1,1,7,0,0,4'b1001),   // R4
        v(4,0,1,1,7,0,0,4'b1001),   // R4
        v(6,0,1,1,7,0,1,4'b1001),   // R6 cancel into fast
        v(4,0,1,1,7,0,0,4'b1001),   // R4
        v(4,0,1,1,7,0,0,4'b1001),   // R4
        v(4,0,1,1,7,0,0,4'b1001),   // R4
        v(4,0,1,1,7,0,0,4'b1001),   // R4
        v(4,0,1,1,7,0,0,4'b1001),   // R4
        v(4,0,1,1,7,0,0,4'b1001),   // R4
        v(4,0,1,1,7,0,0,4'b1001),   // R4
        v(1,0,1,1,7,0,0,4'b0000),   // R1
        v(1,0,1,1,7,0,0,4'b0110),   // R1 polarity 1 charge
        v(4,0,1,1,7,1,0,4'b0000),   // R4
        v(4,0,1,1,7,0,0,4'b1001),   // R4
        // code 0 (fast only in slot 7)
        v(3,0,1,1,0,0,0,4'b1001),   // R3 fast holds to period end
        v(3,0,1,1,0,0,0,4'b1001),   // R3
        v(3,0,1,1,0,0,0,4'b1001),   // R3
        v(3,0,1,1,0,0,0,4'b1001),   // R3
        v(1,0,1,1,0,0,0,4'b0000),   // R1
        v(2,0,1,1,0,1,0,4'b0101),   // R2
        v(3,0,1,1,0,0,0,4'b0101),   // R3
        v(3,0,1,1,0,0,0,4'b0101),   // R3
        v(3,0,1,1,0,0,0,4'b0101),   // R3
        v(3,0,1,1,0,0,0,4'b0101),   // R3
        v(3,0,1,1,0,0,0,4'b0101),   // R3
        v(3,0,1,1,0,0,0,4'b0000)    // R3 fast at slot 7
    };

    function automatic logic [3:0] outs();
        return {hi_a, lo_a, hi_b, lo_b};
    endfunction

    task automatic check(input logic [3:0] exp, input int req, input string what);
        n_vec++;
        if (outs() !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: got %b expected %b", req, what, outs(), exp);
        end
    endtask

    // Called at a falling edge: apply inputs, cross one rising edge, compare.
    task automatic step(input logic off, input logic pol, input logic en,
                        input logic [2:0] code, input logic n, input logic m,
                        input logic [3:0] exp, input int req);
        all_off = off; polarity = pol; mix_en = en; mix_code = code; nf = n; rnf = m;
        #1;
        if (off) check(4'b0000, req, "immediate blank");
        @(posedge clk);
        @(negedge clk);
        check(exp, req, "after edge");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(4'b0000, 11, "held in reset");            // R11
        rst_n = 1'b1;
        for (int i = 0; i < 64; i++) begin
            step(VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8:6],
                 VEC[i][5], VEC[i][4], VEC[i][3:0], int'(VEC[i][15:12]));
        end
        // R6: end-of-fast overshoot, code 0 -> slow, from all-low
        step(0,1,1,3'd0,0,1,4'b0101, 6);
        step(0,1,1,3'd0,0,0,4'b0101, 6);
        // R9: blank at once, then through the edge
        step(1,1,1,3'd0,0,0,4'b0000, 9);
        // R10: stay low for the rest of the period, restart in charge
        for (int k = 0; k < 5; k++) step(0,1,1,3'd0,1,0,4'b0000, 10);
        step(0,1,1,3'd0,0,0,4'b0110, 10);
        step(0,1,1,3'd0,0,0,4'b0110, 10);
        // R11: asynchronous reset in mid-period
        rst_n = 1'b0;
        #1;
        check(4'b0000, 11, "async reset");
        @(negedge clk);
        check(4'b0000, 11, "reset held");
        rst_n = 1'b1;
        step(0,0,1,3'd0,0,0,4'b1001, 10);               // R10 first tick after reset
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule